// File: doc/BRIEF.md
# Register Page Read Sequencer

This block is the byte-level engine behind the register-read command of a single-wire slave device. A bit-layer front end hands it each received byte and asks it for each byte to transmit. After a read command and a two-byte start address, it streams register bytes from a register-file read port. The address counts upward until the last byte of the register page. The engine then sends a bitwise-inverted CRC16 trailer. After that it answers every further read with all ones until the bus is reset.

The CRC starts from zero at every command. It takes in the command byte, both address bytes and every data byte actually sent. It does not take in its own trailer. The block also raises a one-cycle strobe that tells the input-pin register when to capture the pins. The instant of that strobe depends on where the read starts. If the read starts at the pin-state register, the strobe fires while the top bit of the high address byte arrives. If the read starts below it, the strobe fires while the top bit of the byte just before the pin-state register goes out.

Top module: `regpage_reader`

## Requirements
- R1: After reset or a bus reset, and before any byte arrives, `tx_byte` is FFh and `sample_stb` is low.
- R2: A received command byte F0h is followed by the start address: first the low byte, then the high byte. Data bytes are then sent from that address, rising by one per `tx_req`, with `reg_addr` showing the address of the byte on offer.
- R3: The byte at address 008Fh is the last data byte. The next two transmit bytes are the inverted CRC, low byte first.
- R4: The CRC uses the polynomial x^16+x^15+x^2+1, processed least significant bit first (reflected constant A001h), starting from 0000h. It covers the command byte, both address bytes and every data byte sent.
- R5: Once both CRC bytes have gone, every later transmit byte is FFh until a bus reset.
- R6: A start address above 008Fh yields one data byte of FFh, which enters the CRC, followed by the CRC trailer.
- R7: While the high address byte is being received, a low byte of 88h with zero in the seven lower bits of the incoming high byte makes an `msb_slot` pulse produce exactly one `sample_stb` pulse, one cycle later.
- R8: For a start address below 0088h, `sample_stb` pulses once, one cycle after the `msb_slot` that falls during transmission of the byte at 0087h. A start address above 0088h gives no strobe.
- R9: `bus_rst` returns the engine to waiting for a command from any state and clears the CRC, so a new read after it carries a CRC over only its own bytes.
- R10: A command byte other than F0h makes every transmit byte FFh and gives no strobe until a bus reset.
- R11: `rx_valid` pulses that arrive while data or CRC bytes are being sent do not alter the data sequence or the CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: bus reset detected by the bit layer |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte |
| rx_low7 | input | 7 | Seven low bits of the byte being received, valid with `msb_slot` |
| msb_slot | input | 1 | One-cycle pulse: the most significant bit of the current byte is on the bus |
| tx_req | input | 1 | One-cycle pulse: the bit layer takes `tx_byte` for sending |
| tx_byte | output | 8 | Byte offered for the next transmit slot |
| reg_addr | output | 16 | Register-file read address |
| reg_data | input | 8 | Register-file read data for `reg_addr` (combinational) |
| sample_stb | output | 1 | One-cycle pulse telling the pin register to capture the pins |

## Verification
The bench builds the block with its default parameters: command code F0h, last page address 008Fh and pin-state address 0088h. These values put every boundary within a short run. A read from 0000h crosses the whole page. Reads from 0080h and 0088h reach both strobe paths. A read from 008Fh gives a one-byte read. Starts at 0090h and 0188h exercise the above-page path and the partial-address check on the high byte.

// File: rtl/regpage_pkg.sv
package regpage_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_TA1,
    ST_TA2,
    ST_DATA,
    ST_CRCL,
    ST_CRCH,
    ST_ONES
  } rp_state_e;

  // One byte through a reflected CRC16, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] cin,
                                             input logic [7:0]  din,
                                             input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = cin;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/regpage_crc.sv
module regpage_crc #(
  parameter logic [15:0] POLY = 16'hA001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import regpage_pkg::*;

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc16_step(crc_q, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R9
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 16'h0000));

endmodule

// File: rtl/regpage_sampler.sv
module regpage_sampler #(
  parameter logic [15:0] PIN_ADDR = 16'h0088
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_rst,
  input  logic                   msb_slot,
  input  regpage_pkg::rp_state_e state,
  input  logic [7:0]             ta_lo,
  input  logic [6:0]             rx_low7,
  input  logic [15:0]            cur_addr,
  input  logic                   below_pin,
  output logic                   sample_stb
);
  import regpage_pkg::*;

  logic stb_q, stb_d;
  logic hit_addr_phase, hit_data_phase;

  // Pin register targeted directly: strobe while the high address byte's top bit arrives.
  assign hit_addr_phase = (state == ST_TA2) && (ta_lo == PIN_ADDR[7:0]) &&
                          (rx_low7 == PIN_ADDR[14:8]);
  // Started below the pin register: the byte just before it is in flight
  // once the address counter has stepped onto the pin register.
  assign hit_data_phase = (state == ST_DATA) && below_pin && (cur_addr == PIN_ADDR);

  always_comb begin
    stb_d = 1'b0;
    if (msb_slot && !bus_rst) stb_d = hit_addr_phase | hit_data_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign sample_stb = stb_q;

  // R7
  stb_follows_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(msb_slot));

endmodule

// File: rtl/regpage_reader.sv
module regpage_reader #(
  parameter logic [7:0]  CMD_READ  = 8'hF0,
  parameter logic [15:0] PAGE_LAST = 16'h008F,
  parameter logic [15:0] PIN_ADDR  = 16'h0088,
  parameter logic [15:0] CRC_POLY  = 16'hA001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [6:0]  rx_low7,
  input  logic        msb_slot,
  input  logic        tx_req,
  output logic [7:0]  tx_byte,
  output logic [15:0] reg_addr,
  input  logic [7:0]  reg_data,
  output logic        sample_stb
);
  import regpage_pkg::*;

  localparam int AW = 16;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  rp_state_e         state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [7:0]        ta_lo_q, ta_lo_d;
  logic              below_q, below_d;
  logic              crc_en;
  logic [7:0]        crc_din;
  logic [15:0]       crc;
  logic [AW-1:0]     ta_full;

  assign ta_full = {rx_byte, ta_lo_q};

  // Transmit byte selection
  always_comb begin
    unique case (state_q)
      ST_DATA: tx_byte = (addr_q <= PAGE_LAST) ? reg_data : IDLE_BYTE;
      ST_CRCL: tx_byte = ~crc[7:0];
      ST_CRCH: tx_byte = ~crc[15:8];
      default: tx_byte = IDLE_BYTE;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    ta_lo_d = ta_lo_q;
    below_d = below_q;
    crc_en  = 1'b0;
    crc_din = rx_byte;
    if (bus_rst) begin
      state_d = ST_CMD;
    end else begin
      unique case (state_q)
        ST_CMD: if (rx_valid) begin
          crc_en  = 1'b1;
          state_d = (rx_byte == CMD_READ) ? ST_TA1 : ST_ONES;
        end
        ST_TA1: if (rx_valid) begin
          crc_en  = 1'b1;
          ta_lo_d = rx_byte;
          state_d = ST_TA2;
        end
        ST_TA2: if (rx_valid) begin
          crc_en  = 1'b1;
          addr_d  = ta_full;
          below_d = (ta_full < PIN_ADDR);
          state_d = ST_DATA;
        end
        ST_DATA: if (tx_req) begin
          crc_en  = 1'b1;
          crc_din = tx_byte;
          if (addr_q >= PAGE_LAST) state_d = ST_CRCL;
          else                     addr_d  = addr_q + 1'b1;
        end
        ST_CRCL: if (tx_req) state_d = ST_CRCH;
        ST_CRCH: if (tx_req) state_d = ST_ONES;
        default: state_d = state_q;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      addr_q  <= '0;
      ta_lo_q <= '0;
      below_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      ta_lo_q <= ta_lo_d;
      below_q <= below_d;
    end
  end

  assign reg_addr = addr_q;

  regpage_crc #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bus_rst),
    .en    (crc_en),
    .din   (crc_din),
    .crc   (crc)
  );

  regpage_sampler #(.PIN_ADDR(PIN_ADDR)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .msb_slot   (msb_slot),
    .state      (state_q),
    .ta_lo      (ta_lo_q),
    .rx_low7    (rx_low7),
    .cur_addr   (addr_q),
    .below_pin  (below_q),
    .sample_stb (sample_stb)
  );

  // R9
  bus_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (state_q == ST_CMD));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && tx_req && !bus_rst && addr_q < PAGE_LAST)
      |=> (reg_addr == $past(reg_addr) + 16'd1));

  // R5
  ones_after_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRCH && tx_req && !bus_rst) |=> (tx_byte == 8'hFF));

  // R3
  crc_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && tx_req && !bus_rst && addr_q >= PAGE_LAST)
      |=> (state_q == ST_CRCL));

endmodule

// File: tb/regpage_reader_test.sv
`timescale 1ns/1ps
module regpage_reader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [6:0]  rx_low7 = 7'h00;
  logic        msb_slot = 1'b0;
  logic        tx_req = 1'b0;
  logic [7:0]  tx_byte;
  logic [15:0] reg_addr;
  logic [7:0]  reg_data;
  logic        sample_stb;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regpage_reader uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_low7(rx_low7), .msb_slot(msb_slot),
    .tx_req(tx_req), .tx_byte(tx_byte), .reg_addr(reg_addr),
    .reg_data(reg_data), .sample_stb(sample_stb)
  );

  // Register-file model
  function automatic logic [7:0] reg_model(input logic [15:0] a);
    return a[7:0] ^ 8'h5A ^ {a[3:0], a[7:4]};
  endfunction
  assign reg_data = reg_model(reg_addr);

  always @(negedge clk) if (sample_stb) stb_cnt++;

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rx_low7 = b[6:0]; msb_slot = 1'b1;
    @(negedge clk); msb_slot = 1'b0; rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic read_tx(output logic [7:0] b);
    @(negedge clk); b = tx_byte; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; msb_slot = 1'b1;
    @(negedge clk); msb_slot = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  // Full read from start, with an optional stray received byte after the first data byte.
  task automatic run_read(input logic [15:0] start, input int n_data,
                          input int n_stb, input bit inject, input string tag);
    logic [15:0] c;
    logic [7:0]  b, e;
    logic [15:0] a;
    int          bad;
    pulse_bus_rst();
    stb_cnt = 0;
    c = 16'h0;
    send_rx(8'hF0);       c = crc_ref(c, 8'hF0);
    send_rx(start[7:0]);  c = crc_ref(c, start[7:0]);
    send_rx(start[15:8]); c = crc_ref(c, start[15:8]);
    a = start;
    bad = 0;
    for (int i = 0; i < n_data; i++) begin
      read_tx(b);
      e = (a <= 16'h008F) ? reg_model(a) : 8'hFF;
      if (b !== e) begin
        bad++;
        if (bad == 1) $display("FAIL R2/R6 %s: byte %0d actual %h expected %h", tag, i, b, e);
      end
      c = crc_ref(c, e);
      a = a + 16'd1;
      if (inject && i == 0) send_rx(8'h00); // R11
    end
    checks++; if (bad != 0) errors++;
    read_tx(b); chk({"R3/R4 crc lo ", tag}, {8'h0, b}, {8'h0, ~c[7:0]});
    read_tx(b); chk({"R3/R4 crc hi ", tag}, {8'h0, b}, {8'h0, ~c[15:8]});
    read_tx(b); chk({"R5 ones ", tag}, {8'h0, b}, 16'h00FF);
    read_tx(b); chk({"R5 ones again ", tag}, {8'h0, b}, 16'h00FF);
    chk({"R7/R8 strobe count ", tag}, 16'(stb_cnt), 16'(n_stb));
  endtask

  // start, data bytes, strobes
  localparam int NV = 7;
  localparam logic [31:0] VECS [NV] = '{
    {16'h0080, 8'd16,  8'd1},
    {16'h0088, 8'd8,   8'd1},
    {16'h008F, 8'd1,   8'd0},
    {16'h0000, 8'd144, 8'd1},
    {16'h0090, 8'd1,   8'd0},
    {16'h0188, 8'd1,   8'd0},
    {16'h0089, 8'd7,   8'd0}
  };

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset tx_byte", {8'h0, tx_byte}, 16'h00FF);
    chk("R1 reset strobe", {15'h0, sample_stb}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_read(VECS[v][31:16], int'(VECS[v][15:8]), int'(VECS[v][7:0]), 1'b0, $sformatf("vec%0d", v));

    // R11: stray received byte during streaming
    run_read(16'h008C, 4, 0, 1'b1, "inject");

    // R10: unknown command
    pulse_bus_rst();
    stb_cnt = 0;
    send_rx(8'hCC);
    read_tx(b); chk("R10 unknown cmd byte0", {8'h0, b}, 16'h00FF);
    read_tx(b); chk("R10 unknown cmd byte1", {8'h0, b}, 16'h00FF);
    chk("R10 unknown cmd strobe", 16'(stb_cnt), 16'd0);

    // R9: bus reset mid-stream, then a clean read with fresh CRC
    pulse_bus_rst();
    send_rx(8'hF0); send_rx(8'h80); send_rx(8'h00);
    read_tx(b); read_tx(b); read_tx(b);
    pulse_bus_rst();
    @(negedge clk);
    chk("R9 idle after bus reset", {8'h0, tx_byte}, 16'h00FF);
    run_read(16'h0086, 10, 1, 1'b0, "after_rst");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule